// File: doc/BRIEF.md
# Word Load/Store Pair Fusion and Store Split Stage

This dispatch-stage block looks at the two oldest decoded instructions, slot A (older) and slot B (younger). Two word loads, or two word stores, can be merged into one bonded memory operation when they address neighbouring, aligned words off the same base register. A small confidence table, indexed by the program counter of slot A, must also allow the merge. The load-store unit trains this table. It may teach "mergeable" only for accesses to cacheable or write-combining memory. Any other report wipes the confidence for that entry.

The block also marks which stores are split into an address micro-op (one register source) and a data micro-op (two register sources). A bonded store needs three sources in total: one base and two data registers. Splitting it keeps every execution pipe at two read ports or fewer. Floating-point stores are always split. A single integer store is never split, whether it is aligned or not, because a misaligned store places its data according to its address.

The output is one queue entry per cycle, offered with valid/ready. A bonded pair fills one entry and uses up both slots. The `slotsTaken` output tells the upstream buffer how many instructions to retire in that cycle.

Top module: `memPairFuser`

## Requirements
- R1: A pair is bonded (`outBonded`=1, `outReg1`=slot B register) only when all of these hold: both slots are valid; both kinds are equal and are word load (kind 1) or word store (kind 2); the base registers match; `bOff` equals `aOff`+4 (modulo 2^OFF_W); `aOff[2:0]` is 0; and the confidence counter for slot A is 2 or more.
- R2: When any condition of R1 fails, the entry carries slot A alone: `outBonded`=0 and `outReg1`=0.
- R3: Each confidence counter is 2 bits wide and indexed by `pc[IDX_W+1:2]`. A training report with `trainBondOk`=1 and `trainMemType` equal to cacheable (1) or write-combining (2) increments the counter, which saturates at 3. Any other report clears it to 0. The change is visible from the next cycle.
- R4: One successful training report after a clear is not enough to bond. A second successful report is needed.
- R5: A bonded word-store pair is always split (`outCracked`=1).
- R6: A floating-point store (kind 3) is always split and is never bonded.
- R7: A single word store, aligned or misaligned (`aOff[1:0]`≠0), is not split. Loads and other kinds (kind 0) are never split.
- R8: `outValid` follows `aValid`. `slotsTaken` is 0 unless `outValid` and `outReady` are both 1. In that case it is 2 for a bonded entry and 1 otherwise.
- R9: After reset every counter is 0, so no pair bonds until training has occurred.
- R10: Training one counter index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| aValid | input | 1 | slot A holds an instruction |
| aKind | input | 2 | slot A kind: 0 other, 1 word load, 2 word store, 3 FP store |
| aPc | input | PC_W | slot A program counter |
| aBase | input | REG_W | slot A base register |
| aReg | input | REG_W | slot A load destination or store data register |
| aOff | input | OFF_W | slot A immediate offset |
| bValid | input | 1 | slot B holds an instruction |
| bKind | input | 2 | slot B kind |
| bBase | input | REG_W | slot B base register |
| bReg | input | REG_W | slot B load destination or store data register |
| bOff | input | OFF_W | slot B immediate offset |
| trainValid | input | 1 | training report present |
| trainPc | input | PC_W | program counter of the reported access |
| trainBondOk | input | 1 | the merged access completed correctly |
| trainMemType | input | 2 | 0 uncached, 1 cacheable, 2 write-combining, 3 device |
| outReady | input | 1 | downstream queue has a free entry |
| outValid | output | 1 | entry offered |
| outKind | output | 2 | kind of the entry |
| outPc | output | PC_W | program counter of the entry |
| outBase | output | REG_W | base register |
| outReg0 | output | REG_W | first data or destination register |
| outReg1 | output | REG_W | second register when bonded, else 0 |
| outOffset | output | OFF_W | offset of the lower word |
| outBonded | output | 1 | entry covers two instructions |
| outCracked | output | 1 | entry splits into address and data micro-ops |
| slotsTaken | output | 2 | instructions retired from the slots this cycle |

## Verification
The bench uses the default parameters: a 16-entry table indexed by PC bits 5:2, with 16-bit offsets. With so few entries, one program counter and a second one that differs only in bit 2 select neighbouring counters. This lets the bench show that a trained entry does not leak to its neighbour. The offsets are narrow enough to reach the alignment and adjacency edges directly: a pair starting at offset 4, a stride of 8, and reversed order. The bench also drives training reports several times in a row to reach counter saturation, then clears the counter with an uncached report and with a failed report.

// File: rtl/memPairPkg.sv
package memPairPkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_LDW   = 2'd1,
    KIND_STW   = 2'd2,
    KIND_FPST  = 2'd3
  } instKind_t;

  localparam logic [1:0] MEM_CACHEABLE = 2'd1;
  localparam logic [1:0] MEM_WCOMB     = 2'd2;

  typedef struct packed {
    logic fuse;
    logic crack;
    logic take;
  } ctrlStrobes_t;
endpackage

// File: rtl/pairBondPredictor.sv
module pairBondPredictor import memPairPkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lookupIdx,
  output logic             predictOk,
  input  logic             trainValid,
  input  logic [IDX_W-1:0] trainIdx,
  input  logic             trainBondOk,
  input  logic [1:0]       trainMemType
);
  logic [1:0] ctr [DEPTH];
  logic       goodTrain;

  assign goodTrain = trainBondOk &&
                     (trainMemType == MEM_CACHEABLE || trainMemType == MEM_WCOMB);
  assign predictOk = ctr[lookupIdx][1];

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctr[e] <= 2'd0;
      end else if (trainValid && trainIdx == IDX_W'(e)) begin
        if (!goodTrain)          ctr[e] <= 2'd0;
        else if (ctr[e] != 2'd3) ctr[e] <= ctr[e] + 2'd1;
      end
    end
  end
endmodule

// File: rtl/pairFuseCtrl.sv
module pairFuseCtrl import memPairPkg::*; #(
  parameter int REG_W = 5,
  parameter int OFF_W = 16
) (
  input  logic             aValid,
  input  instKind_t        aKind,
  input  logic [REG_W-1:0] aBase,
  input  logic [OFF_W-1:0] aOff,
  input  logic             bValid,
  input  instKind_t        bKind,
  input  logic [REG_W-1:0] bBase,
  input  logic [OFF_W-1:0] bOff,
  input  logic             predictOk,
  input  logic             outReady,
  output ctrlStrobes_t     strobes
);
  logic sameClass, adjacent, pairAligned, pairOk;

  always_comb begin
    sameClass   = (aKind == bKind) && (aKind == KIND_LDW || aKind == KIND_STW);
    adjacent    = (aBase == bBase) && (bOff == aOff + OFF_W'(4));
    pairAligned = (aOff[2:0] == 3'b000);
    pairOk      = aValid && bValid && sameClass && adjacent && pairAligned && predictOk;
    strobes.fuse  = pairOk;
    strobes.crack = aValid && ((aKind == KIND_FPST) || (aKind == KIND_STW && pairOk));
    strobes.take  = aValid && outReady;
  end
endmodule

// File: rtl/pairFuseDatapath.sv
module pairFuseDatapath import memPairPkg::*; #(
  parameter int PC_W  = 32,
  parameter int REG_W = 5,
  parameter int OFF_W = 16
) (
  input  ctrlStrobes_t     strobes,
  input  logic             aValid,
  input  logic [1:0]       aKind,
  input  logic [PC_W-1:0]  aPc,
  input  logic [REG_W-1:0] aBase,
  input  logic [REG_W-1:0] aReg,
  input  logic [OFF_W-1:0] aOff,
  input  logic [REG_W-1:0] bReg,
  output logic             outValid,
  output logic [1:0]       outKind,
  output logic [PC_W-1:0]  outPc,
  output logic [REG_W-1:0] outBase,
  output logic [REG_W-1:0] outReg0,
  output logic [REG_W-1:0] outReg1,
  output logic [OFF_W-1:0] outOffset,
  output logic             outBonded,
  output logic             outCracked,
  output logic [1:0]       slotsTaken
);
  always_comb begin
    outValid   = aValid;
    outKind    = aKind;
    outPc      = aPc;
    outBase    = aBase;
    outReg0    = aReg;
    outReg1    = strobes.fuse ? bReg : '0;
    outOffset  = aOff;
    outBonded  = strobes.fuse;
    outCracked = strobes.crack;
    if (!strobes.take)     slotsTaken = 2'd0;
    else if (strobes.fuse) slotsTaken = 2'd2;
    else                   slotsTaken = 2'd1;
  end
endmodule

// File: rtl/memPairFuser.sv
module memPairFuser import memPairPkg::*; #(
  parameter int PC_W       = 32,
  parameter int REG_W      = 5,
  parameter int OFF_W      = 16,
  parameter int PRED_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aValid,
  input  logic [1:0]       aKind,
  input  logic [PC_W-1:0]  aPc,
  input  logic [REG_W-1:0] aBase,
  input  logic [REG_W-1:0] aReg,
  input  logic [OFF_W-1:0] aOff,
  input  logic             bValid,
  input  logic [1:0]       bKind,
  input  logic [REG_W-1:0] bBase,
  input  logic [REG_W-1:0] bReg,
  input  logic [OFF_W-1:0] bOff,
  input  logic             trainValid,
  input  logic [PC_W-1:0]  trainPc,
  input  logic             trainBondOk,
  input  logic [1:0]       trainMemType,
  input  logic             outReady,
  output logic             outValid,
  output logic [1:0]       outKind,
  output logic [PC_W-1:0]  outPc,
  output logic [REG_W-1:0] outBase,
  output logic [REG_W-1:0] outReg0,
  output logic [REG_W-1:0] outReg1,
  output logic [OFF_W-1:0] outOffset,
  output logic             outBonded,
  output logic             outCracked,
  output logic [1:0]       slotsTaken
);
  localparam int IDX_W = $clog2(PRED_DEPTH);

  ctrlStrobes_t strobes;
  logic         predictOk;
  logic         unusedTrainBits;

  assign unusedTrainBits = ^{trainPc[PC_W-1:IDX_W+2], trainPc[1:0]};

  pairBondPredictor #(.DEPTH(PRED_DEPTH)) uPred (
    .clk(clk), .rstN(rstN),
    .lookupIdx(aPc[IDX_W+1:2]), .predictOk(predictOk),
    .trainValid(trainValid), .trainIdx(trainPc[IDX_W+1:2]),
    .trainBondOk(trainBondOk), .trainMemType(trainMemType)
  );

  pairFuseCtrl #(.REG_W(REG_W), .OFF_W(OFF_W)) uCtrl (
    .aValid(aValid), .aKind(instKind_t'(aKind)), .aBase(aBase), .aOff(aOff),
    .bValid(bValid), .bKind(instKind_t'(bKind)), .bBase(bBase), .bOff(bOff),
    .predictOk(predictOk), .outReady(outReady), .strobes(strobes)
  );

  pairFuseDatapath #(.PC_W(PC_W), .REG_W(REG_W), .OFF_W(OFF_W)) uPath (
    .strobes(strobes), .aValid(aValid), .aKind(aKind), .aPc(aPc),
    .aBase(aBase), .aReg(aReg), .aOff(aOff), .bReg(bReg),
    .outValid(outValid), .outKind(outKind), .outPc(outPc), .outBase(outBase),
    .outReg0(outReg0), .outReg1(outReg1), .outOffset(outOffset),
    .outBonded(outBonded), .outCracked(outCracked), .slotsTaken(slotsTaken)
  );
endmodule

// File: rtl/memPairFuserChecker.sv
module memPairFuserChecker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             aValid,
  input logic             bValid,
  input logic [1:0]       aKind,
  input logic [1:0]       bKind,
  input logic [1:0]       aOffLow,
  input logic [IDX_W-1:0] aIdx,
  input logic             trainValid,
  input logic [IDX_W-1:0] trainIdx,
  input logic             trainBondOk,
  input logic [1:0]       trainMemType,
  input logic             outReady,
  input logic             outValid,
  input logic [1:0]       outKind,
  input logic             outBonded,
  input logic             outCracked,
  input logic [1:0]       slotsTaken
);
  // R1: a bonded entry needs two valid slots of one word kind
  assert_pair_shape_R1: assert property (@(posedge clk) disable iff (!rstN)
    outBonded |-> (aValid && bValid && aKind == bKind && (aKind == 2'd1 || aKind == 2'd2)));

  // R3: a bad report clears that entry, so the next cycle cannot bond there
  assert_clear_on_bad_train_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trainValid && !(trainBondOk && (trainMemType == 2'd1 || trainMemType == 2'd2)))
      |=> !(outBonded && aIdx == $past(trainIdx)));

  // R5: bonded stores are split
  assert_bonded_store_split_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outBonded && outKind == 2'd2) |-> outCracked);

  // R6: floating-point stores are split and never bonded
  assert_fp_store_split_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd3) |-> (outCracked && !outBonded));

  // R7: misaligned integer stores stay whole
  assert_misaligned_whole_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd2 && aOffLow != 2'b00) |-> !outCracked);

  // R8: retirement only on a handshake
  assert_take_on_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotsTaken != 2'd0) |-> (outValid && outReady && (slotsTaken == 2'd2) == outBonded));
endmodule

bind memPairFuser memPairFuserChecker #(.IDX_W(IDX_W)) uChecker (
  .clk(clk), .rstN(rstN), .aValid(aValid), .bValid(bValid),
  .aKind(aKind), .bKind(bKind), .aOffLow(aOff[1:0]), .aIdx(aPc[IDX_W+1:2]),
  .trainValid(trainValid), .trainIdx(trainPc[IDX_W+1:2]),
  .trainBondOk(trainBondOk), .trainMemType(trainMemType), .outReady(outReady),
  .outValid(outValid), .outKind(outKind), .outBonded(outBonded),
  .outCracked(outCracked), .slotsTaken(slotsTaken)
);

// File: tb/tb_memPairFuser.sv
module tb_memPairFuser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aValid = 0, bValid = 0, trainValid = 0, trainBondOk = 0, outReady = 0;
  logic [1:0] aKind = 0, bKind = 0, trainMemType = 0;
  logic [31:0] aPc = 0, trainPc = 0;
  logic [4:0] aBase = 0, aReg = 0, bBase = 0, bReg = 0;
  logic [15:0] aOff = 0, bOff = 0;
  logic outValid, outBonded, outCracked;
  logic [1:0] outKind, slotsTaken;
  logic [31:0] outPc;
  logic [4:0] outBase, outReg0, outReg1;
  logic [15:0] outOffset;

  int vectors = 0, errs = 0;
  int ctr[16];
  bit done = 0;

  always #5 clk = ~clk;

  memPairFuser dut (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aKind(aKind), .aPc(aPc),
    .aBase(aBase), .aReg(aReg), .aOff(aOff), .bValid(bValid), .bKind(bKind),
    .bBase(bBase), .bReg(bReg), .bOff(bOff), .trainValid(trainValid),
    .trainPc(trainPc), .trainBondOk(trainBondOk), .trainMemType(trainMemType),
    .outReady(outReady), .outValid(outValid), .outKind(outKind), .outPc(outPc),
    .outBase(outBase), .outReg0(outReg0), .outReg1(outReg1),
    .outOffset(outOffset), .outBonded(outBonded), .outCracked(outCracked),
    .slotsTaken(slotsTaken)
  );

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setPair(logic av, logic [1:0] ak, logic [31:0] pc, logic [4:0] ab,
                         logic [15:0] ao, logic bv, logic [1:0] bk, logic [4:0] bb,
                         logic [15:0] bo, logic rdy);
    aValid = av; aKind = ak; aPc = pc; aBase = ab; aReg = 5'd7; aOff = ao;
    bValid = bv; bKind = bk; bBase = bb; bReg = 5'd9; bOff = bo; outReady = rdy;
  endtask

  task automatic train(logic [31:0] pc, logic ok, logic [1:0] mt);
    trainValid = 1; trainPc = pc; trainBondOk = ok; trainMemType = mt;
  endtask

  // Inputs are set after an edge; compare here, then advance one clock.
  task automatic tick(string req);
    bit fuse, crack;
    int takeExp;
    #1;
    fuse = aValid && bValid && aKind == bKind && (aKind == 2'd1 || aKind == 2'd2) &&
           aBase == bBase && bOff == 16'(aOff + 16'd4) && aOff[2:0] == 3'd0 &&
           ctr[aPc[5:2]] >= 2;
    crack = aValid && (aKind == 2'd3 || (aKind == 2'd2 && fuse));
    takeExp = (aValid && outReady) ? (fuse ? 2 : 1) : 0;
    cmp(req, "outValid", int'(outValid), int'(aValid));
    cmp(req, "outBonded", int'(outBonded), int'(fuse));
    cmp(req, "outCracked", int'(outCracked), int'(crack));
    cmp(req, "outReg1", int'(outReg1), fuse ? int'(bReg) : 0);
    cmp(req, "slotsTaken", int'(slotsTaken), takeExp);
    if (trainValid) begin
      if (trainBondOk && (trainMemType == 2'd1 || trainMemType == 2'd2))
        ctr[trainPc[5:2]] = (ctr[trainPc[5:2]] == 3) ? 3 : ctr[trainPc[5:2]] + 1;
      else
        ctr[trainPc[5:2]] = 0;
    end
    @(posedge clk);
    #1;
    trainValid = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    foreach (ctr[i]) ctr[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R8 reset state: idle
    tick("R8_idle");
    // R9: fresh table, well formed load pair does not bond
    setPair(1, 1, 32'h100, 3, 16'd0, 1, 1, 3, 16'd4, 1);
    tick("R9_fresh");
    // R4: one good report is not enough
    train(32'h100, 1, 2'd1);
    tick("R4_train1");
    tick("R4_after1");
    train(32'h100, 1, 2'd2);
    tick("R4_train2");
    // R1: bonded load pair
    tick("R1_load_pair");
    // R8: stall
    outReady = 0;
    tick("R8_stall");
    outReady = 1;
    // R2 failures
    setPair(1, 1, 32'h100, 3, 16'd4, 1, 1, 3, 16'd8, 1); tick("R2_misaligned_pair");
    setPair(1, 1, 32'h100, 3, 16'd0, 1, 1, 4, 16'd4, 1); tick("R2_base_differs");
    setPair(1, 1, 32'h100, 3, 16'd0, 1, 1, 3, 16'd8, 1); tick("R2_stride8");
    setPair(1, 1, 32'h100, 3, 16'd4, 1, 1, 3, 16'd0, 1); tick("R2_reversed");
    setPair(1, 1, 32'h100, 3, 16'd0, 1, 2, 3, 16'd4, 1); tick("R2_mixed_kind");
    setPair(1, 1, 32'h100, 3, 16'd0, 0, 1, 3, 16'd4, 1); tick("R2_b_invalid");
    setPair(1, 0, 32'h100, 3, 16'd0, 1, 0, 3, 16'd4, 1); tick("R7_other_kind");
    setPair(1, 1, 32'h100, 3, 16'd8, 1, 1, 3, 16'd12, 1); tick("R1_offset8");
    // R5: bonded store pair is split
    setPair(1, 2, 32'h100, 3, 16'd16, 1, 2, 3, 16'd20, 1); tick("R5_store_pair");
    // R6: FP store pair: split, not bonded
    setPair(1, 3, 32'h100, 3, 16'd0, 1, 3, 3, 16'd4, 1); tick("R6_fp_pair");
    setPair(1, 3, 32'h100, 3, 16'd2, 0, 0, 3, 16'd0, 1); tick("R6_fp_single");
    // R7: single stores whole
    setPair(1, 2, 32'h100, 3, 16'd2, 0, 0, 0, 16'd0, 1); tick("R7_misaligned_store");
    setPair(1, 2, 32'h100, 3, 16'd0, 0, 0, 0, 16'd0, 1); tick("R7_single_store");
    // R10: neighbour index untouched
    setPair(1, 1, 32'h104, 3, 16'd0, 1, 1, 3, 16'd4, 1); tick("R10_neighbour");
    // R3: saturation then clear by uncached report
    setPair(1, 1, 32'h100, 3, 16'd0, 1, 1, 3, 16'd4, 1);
    for (int k = 0; k < 4; k++) begin train(32'h100, 1, 2'd1); tick("R3_saturate"); end
    tick("R3_saturated_bonds");
    train(32'h100, 1, 2'd0); tick("R3_uncached_train");
    tick("R3_cleared");
    train(32'h100, 1, 2'd1); tick("R3_retrain1");
    train(32'h100, 1, 2'd2); tick("R3_retrain2");
    tick("R3_bond_again");
    train(32'h100, 0, 2'd1); tick("R3_fail_train");
    tick("R3_cleared_fail");
    train(32'h100, 1, 2'd3); tick("R3_device_train");
    tick("R3_device_no_bond");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule